// File: doc/BRIEF.md
# Clocked Acknowledge Delay Gate

This block sits between a fast processor and a slower legacy peripheral bus. It holds back the active-low transfer acknowledge coming from the slow bus until a programmable number of processor clock cycles have passed since the processor asserted its active-low data strobe. The delay is made by a counter on the processor clock, not by chained gates or an analog network, so it is exact and tied to the processor's own bus timing. When the processor clock runs faster, a larger cycle count gives the same delay in nanoseconds. For example, at 24 MHz a cycle is about 41 ns, so more cycles are needed than at 16 MHz.

Both the strobe and the slow acknowledge pass through a two-flop synchroniser. A four-state machine then decides when the acknowledge may reach the processor:

- `ST_IDLE`: no bus cycle is active.
- `ST_COUNT`: the delay is elapsing.
- `ST_OPEN`: the delay has expired and the gate waits for the slow acknowledge.
- `ST_ACKED`: the acknowledge is being delivered.

The transitions are:

- `ST_IDLE` goes to `ST_COUNT` on strobe assertion, or straight to `ST_OPEN` if the setting is zero.
- `ST_COUNT` goes to `ST_OPEN` when the count reaches the setting.
- `ST_OPEN` goes to `ST_ACKED` when the slow acknowledge is low.
- `ST_ACKED` goes back to `ST_OPEN` when the slow acknowledge rises.
- Every state goes to `ST_IDLE` when the synchronised strobe goes inactive.

Latency convention: inputs change between clock edges. Cycle numbers below count rising edges after that change.

Top module: `ack_delay_gate`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe, `cpu_ack_n` is high (inactive).
- R2: The strobe and the slow acknowledge each pass through two clocked flops before any use. With a setting of 0 and the slow acknowledge already low, `cpu_ack_n` cannot go low before the third edge after strobe assertion.
- R3: With the slow acknowledge already low and a setting of D in the range 1 to 15, `cpu_ack_n` first goes low exactly after the edge numbered 3+D following strobe assertion.
- R4: A setting of 0 adds no counted cycles. `cpu_ack_n` goes low after edge 3, from synchronisation and state update only.
- R5: The largest setting, 15, delays the acknowledge until edge 18.
- R6: If the slow acknowledge is still high when the count expires, `cpu_ack_n` stays high. It goes low 2 edges after the slow acknowledge goes low.
- R7: When the strobe goes inactive, `cpu_ack_n` is high after the second edge, with no further wait, and the count clears.
- R8: A slow acknowledge still held low from the previous cycle does not end the next bus cycle early. `cpu_ack_n` stays high until edge 3+D of the new cycle.
- R9: A strobe released before the count expires produces no acknowledge pulse at all.
- R10: While the strobe stays active after the gate opens, `cpu_ack_n` follows the slow acknowledge. A rise of the slow acknowledge appears 2 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Processor data strobe, active low, asynchronous |
| slow_ack_n | input | 1 | Acknowledge from the slow bus, active low, asynchronous |
| delay_cycles | input | CNT_W (4) | Number of processor cycles to hold the acknowledge back |
| cpu_ack_n | output | 1 | Gated acknowledge to the processor, active low |

## Verification
The assertions assume that the delay setting stays stable while a synchronised strobe is active. They also assume that the strobe and the slow acknowledge change at most once per clock period, so the synchroniser output is a clean delayed copy. The stimulus respects both assumptions. It changes the setting only when the gate is idle, with at least four idle cycles between bus cycles. It drives every input on the falling clock edge, one change at a time. The checker measures the delay with its own cycle count since the synchronised strobe fell. It then requires that a delivered acknowledge never appears before that count exceeds the setting.

// File: rtl/adg_pkg.sv
package adg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_OPEN  = 2'd2,
        ST_ACKED = 2'd3
    } adg_state_e;

endpackage

// File: rtl/adg_sync.sv
module adg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/adg_counter.sv
module adg_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run) begin
            count_q <= '0;
        end else if (count_q != CNT_MAX) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign done = (count_q >= limit);

endmodule

// File: rtl/ack_delay_gate.sv
module ack_delay_gate #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_n,
    input  logic             slow_ack_n,
    input  logic [CNT_W-1:0] delay_cycles,
    output logic             cpu_ack_n
);
    import adg_pkg::*;

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              strb_s;
    logic              ack_s;
    logic              cnt_done;
    adg_state_e        state_q;
    adg_state_e        state_d;

    assign raw_in = {strobe_n, slow_ack_n};

    adg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (synced)
    );

    assign strb_s = synced[1];
    assign ack_s  = synced[0];

    adg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!strb_s),
        .limit (delay_cycles),
        .done  (cnt_done)
    );

    always_comb begin
        state_d = state_q;
        if (strb_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = cnt_done ? ST_OPEN : ST_COUNT;
                ST_COUNT: if (cnt_done) state_d = ST_OPEN;
                ST_OPEN:  if (!ack_s)   state_d = ST_ACKED;
                ST_ACKED: if (ack_s)    state_d = ST_OPEN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cpu_ack_n = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_COUNT: cpu_ack_n = 1'b1;
            ST_OPEN, ST_ACKED: cpu_ack_n = strb_s | ack_s;
            default:           cpu_ack_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/adg_checker.sv
module adg_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strb_s,
    input logic             ack_s,
    input logic [CNT_W-1:0] delay_cycles,
    input logic             cpu_ack_n
);

    localparam int CC_W = CNT_W + 1;
    localparam logic [CC_W-1:0] CC_MAX = '1;

    logic [CC_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (strb_s) begin
            since_q <= '0;
        end else if (since_q != CC_MAX) begin
            since_q <= since_q + CC_W'(1);
        end
    end

    // R3 / R5 / R8: no acknowledge before the programmed count has elapsed
    a_r3_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack_n |-> (since_q >= CC_W'(delay_cycles) + CC_W'(1)));

    // R6 / R10: delivered acknowledge requires the synchronised slow acknowledge
    a_r6_needs_slow_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack_n |-> !ack_s);

    // R7: inactive strobe forces the output high
    a_r7_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        strb_s |-> cpu_ack_n);

    // R9: a strobe that ends early leaves the output high on the next cycle too
    a_r9_no_late_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_s) |=> cpu_ack_n);

    // R3 input assumption: setting is stable during an active strobe
    a_r3_stable_setting: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_s && !$past(strb_s)) |-> $stable(delay_cycles));

endmodule

bind ack_delay_gate adg_checker #(.CNT_W(CNT_W)) u_adg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb_s       (strb_s),
    .ack_s        (ack_s),
    .delay_cycles (delay_cycles),
    .cpu_ack_n    (cpu_ack_n)
);

// File: tb/tb_ack_delay_gate.sv
module tb_ack_delay_gate;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe_n = 1'b1;
    logic             slow_ack_n = 1'b1;
    logic [CNT_W-1:0] delay_cycles = '0;
    logic             cpu_ack_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    when;
        string req;
    } exp_t;

    exp_t exp_q[$];
    logic prev_ack = 1'b1;

    ack_delay_gate #(.CNT_W(CNT_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_n     (strobe_n),
        .slow_ack_n   (slow_ack_n),
        .delay_cycles (delay_cycles),
        .cpu_ack_n    (cpu_ack_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every falling edge of cpu_ack_n must match the next expected item
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ack && !cpu_ack_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected acknowledge", cyc, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.when, e.req, cyc, e.when);
                end
            end
        end
        prev_ack = cpu_ack_n;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: assert strobe and push the expected acknowledge cycle
    task automatic strobe_on(input int d, input int lat, input string req);
        @(negedge clk);
        delay_cycles = CNT_W'(d);
        strobe_n = 1'b0;
        if (lat >= 0) exp_q.push_back('{cyc + lat, req});
    endtask

    task automatic ack_low(input string req);
        @(negedge clk);
        slow_ack_n = 1'b0;
        exp_q.push_back('{cyc + 2, req});
    endtask

    initial begin
        idle(2);
        check(cpu_ack_n == 1'b1, "R1 in reset", cpu_ack_n, 1);
        rst_n = 1'b1;
        idle(3);
        check(cpu_ack_n == 1'b1, "R1 after reset", cpu_ack_n, 1);

        // R3: ack already low, D=4
        @(negedge clk); slow_ack_n = 1'b0;
        strobe_on(4, 7, "R3 delay 4");
        idle(10);
        check(cpu_ack_n == 1'b0, "R3 held low", cpu_ack_n, 0);
        // R7: release
        @(negedge clk); strobe_n = 1'b1;
        check(cpu_ack_n == 1'b0, "R7 still low before sync", cpu_ack_n, 0);
        idle(1);
        check(cpu_ack_n == 1'b0, "R7 low after one edge", cpu_ack_n, 0);
        idle(1);
        check(cpu_ack_n == 1'b1, "R7 high after two edges", cpu_ack_n, 1);
        idle(2);
        // R8: slow ack still low into the next cycle
        strobe_on(4, 7, "R8 new cycle not early");
        idle(6);
        check(cpu_ack_n == 1'b1, "R8 high before expiry", cpu_ack_n, 1);
        idle(1);
        check(cpu_ack_n == 1'b0, "R8 low at expiry", cpu_ack_n, 0);
        @(negedge clk); strobe_n = 1'b1; slow_ack_n = 1'b1;
        idle(5);

        // R4 / R2: zero delay
        @(negedge clk); slow_ack_n = 1'b0;
        strobe_on(0, 3, "R4 zero delay");
        idle(2);
        check(cpu_ack_n == 1'b1, "R2 sync latency", cpu_ack_n, 1);
        idle(3);
        @(negedge clk); strobe_n = 1'b1;
        idle(5);

        // R3: D=1
        strobe_on(1, 4, "R3 delay 1");
        idle(6);
        @(negedge clk); strobe_n = 1'b1;
        idle(5);

        // R5: max delay
        strobe_on(15, 18, "R5 delay 15");
        idle(17);
        check(cpu_ack_n == 1'b1, "R5 high before 18", cpu_ack_n, 1);
        idle(3);
        @(negedge clk); strobe_n = 1'b1; slow_ack_n = 1'b1;
        idle(5);

        // R6: late slow acknowledge
        strobe_on(2, -1, "");
        idle(8);
        check(cpu_ack_n == 1'b1, "R6 waits for slow ack", cpu_ack_n, 1);
        ack_low("R6 late ack follows");
        idle(3);
        // R10: follow a rise while strobe held
        @(negedge clk); slow_ack_n = 1'b1;
        idle(1);
        check(cpu_ack_n == 1'b0, "R10 low one edge after rise", cpu_ack_n, 0);
        idle(1);
        check(cpu_ack_n == 1'b1, "R10 high two edges after rise", cpu_ack_n, 1);
        ack_low("R10 follows fall again");
        idle(3);
        @(negedge clk); strobe_n = 1'b1; slow_ack_n = 1'b1;
        idle(5);

        // R9: abort before expiry
        @(negedge clk); slow_ack_n = 1'b0;
        strobe_on(10, -1, "");
        idle(5);
        @(negedge clk); strobe_n = 1'b1;
        begin
            bit stayed_high = 1'b1;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (cpu_ack_n != 1'b1) stayed_high = 1'b0;
            end
            check(stayed_high, "R9 abort gives no pulse", stayed_high, 1);
        end
        @(negedge clk); slow_ack_n = 1'b1;
        idle(3);

        check(exp_q.size() == 0, "R3 all expected acknowledges seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule